// File: doc/BRIEF.md
# Thread Interrupt Priority Context

This block keeps the interrupt priority state of one CPU thread. The state is split into four rings, numbered 0 user, 1 OS, 2 pool and 3 physical. Each ring owns a 16-byte register window. A ring holds an 8-bit pending buffer that has one bit per active priority, and a current priority register. It also derives the most favored pending priority from the buffer. Priorities 0 to 7 are active, and 0 is the most favored. The value 0xFF stands for "none" or "least favored".

A presentation port posts a priority to one ring. A register port reads or writes ring registers through one of four privilege pages. A read of the acknowledge offset takes the most favored pending priority. That priority becomes the new current priority, and its pending bit is dropped. Two exception outputs are driven: one for the OS ring and one for the hypervisor-level rings.

Top module: `tipc_top`

## Requirements
- R1: After reset every ring has pending buffer 0x00, current priority 0x00 and pending priority 0xFF, and both exception outputs are low.
- R2: A presentation with priority above 7 leaves the target ring's pending buffer unchanged.
- R3: A presentation of priority p (0..7) to ring r sets bit (7-p) of ring r's pending buffer, which reads back at byte offset 0.
- R4: The pending priority, read at byte offset 2, equals the number of leading zeros of the pending buffer (from bit 7), or 0xFF when the buffer is zero.
- R5: os_irq_o is high when ring 1's pending priority is numerically lower than its current priority. hv_irq_o is the same test ORed over rings 2 and 3. Ring 0 drives no output.
- R6: A write to byte offset 1 sets the ring's current priority, and the exception outputs reflect the new value from the following cycle.
- R7: A read at byte offset 3 returns the pending priority. On that edge the current priority takes this value and its pending bit clears. With an empty buffer the read returns 0xFF and the current priority becomes 0xFF.
- R8: Page pg (0 hardware, 1 hypervisor, 2 OS, 3 user) may reach ring r only when r + pg <= 3. A denied write changes nothing. A denied read returns 0x00 and has no acknowledge effect.
- R9: Offsets other than 0 to 3 read 0x00. Writes to any offset other than 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pres_en_i | input | 1 | Presentation request strobe |
| pres_ring_i | input | 2 | Target ring of the presentation |
| pres_prio_i | input | 8 | Presented priority |
| acc_en_i | input | 1 | Register access strobe |
| acc_we_i | input | 1 | 1 write, 0 read |
| acc_page_i | input | 2 | Privilege page of the access |
| acc_ring_i | input | 2 | Ring addressed |
| acc_off_i | input | 4 | Byte offset inside the ring |
| acc_wdata_i | input | 8 | Write data |
| acc_rdata_o | output | 8 | Read data, combinational in the access cycle |
| hv_irq_o | output | 1 | Exception for the pool or physical ring |
| os_irq_o | output | 1 | Exception for the OS ring |

## Verification
Priorities are presented one at a time and in stacked combinations. This separates bit placement in the buffer from leading-zero selection across several set bits. Out-of-range priorities show that the buffer is untouched. Current-priority writes on both sides of the pending value show the strict less-than compare of each ring, while user-ring traffic shows that ring 0 drives no output. Every page is tried against rings inside and outside its reach, which separates a granted access from a denied one. Acknowledges on full and empty buffers show the priority handover and the 0xFF case.

// File: rtl/tipc_pkg.sv
package tipc_pkg;
  localparam int NUM_RINGS = 4;
  localparam int RING_W    = 2;
  localparam int NUM_PRIO  = 8;
  localparam int DATA_W    = 8;
  localparam int OFF_W     = 4;
  localparam logic [DATA_W-1:0] PRIO_NONE = '1;
  localparam logic [DATA_W-1:0] PRIO_LIM  = DATA_W'(NUM_PRIO);

  typedef enum logic [OFF_W-1:0] {
    OFF_IPB  = 4'd0,
    OFF_CPPR = 4'd1,
    OFF_PIPR = 4'd2,
    OFF_ACK  = 4'd3
  } reg_off_e;

  // priority p -> bit (NUM_PRIO-1-p); out of range -> no bit
  function automatic logic [NUM_PRIO-1:0] prio_to_bit(input logic [DATA_W-1:0] p);
    logic [NUM_PRIO-1:0] b;
    b = '0;
    for (int i = 0; i < NUM_PRIO; i++)
      if (p == DATA_W'(NUM_PRIO-1-i)) b[i] = 1'b1;
    return b;
  endfunction

  // leading-zero count from the top bit, PRIO_NONE when empty
  function automatic logic [DATA_W-1:0] ipb_to_pipr(input logic [NUM_PRIO-1:0] b);
    logic [DATA_W-1:0] r;
    r = PRIO_NONE;
    for (int i = 0; i < NUM_PRIO; i++)
      if (b[i]) r = DATA_W'(NUM_PRIO-1-i);
    return r;
  endfunction
endpackage

// File: rtl/tipc_ring.sv
module tipc_ring
  import tipc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pres_en_i,
  input  logic [DATA_W-1:0] pres_prio_i,
  input  logic              cppr_we_i,
  input  logic [DATA_W-1:0] cppr_wdata_i,
  input  logic              ack_i,
  output logic [NUM_PRIO-1:0] ipb_o,
  output logic [DATA_W-1:0] cppr_o,
  output logic [DATA_W-1:0] pipr_o,
  output logic              irq_o
);
  logic [NUM_PRIO-1:0] ipb_q, ipb_d;
  logic [DATA_W-1:0]   cppr_q;

  assign pipr_o = ipb_to_pipr(ipb_q);
  assign irq_o  = pipr_o < cppr_q;
  assign ipb_o  = ipb_q;
  assign cppr_o = cppr_q;

  // ack clears first, a same-cycle presentation still lands
  always_comb begin
    ipb_d = ipb_q;
    if (ack_i)     ipb_d = ipb_d & ~prio_to_bit(pipr_o);
    if (pres_en_i) ipb_d = ipb_d | prio_to_bit(pres_prio_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ipb_q  <= '0;
      cppr_q <= '0;
    end else begin
      ipb_q <= ipb_d;
      if (ack_i)          cppr_q <= pipr_o;
      else if (cppr_we_i) cppr_q <= cppr_wdata_i;
    end
  end

  a_r3_present_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pres_en_i && pres_prio_i < PRIO_LIM |=> (ipb_q & prio_to_bit($past(pres_prio_i))) != '0);

  a_r2_high_prio_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pres_en_i && pres_prio_i >= PRIO_LIM && !ack_i |=> ipb_q == $past(ipb_q));

  a_r4_pipr_has_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pipr_o < PRIO_LIM |-> (ipb_q & prio_to_bit(pipr_o)) != '0);

  a_r7_ack_cppr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> cppr_q == $past(pipr_o));

  a_r7_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && !pres_en_i |=> (ipb_q & prio_to_bit($past(pipr_o))) == '0);

  a_r6_cppr_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cppr_we_i && !ack_i |=> cppr_q == $past(cppr_wdata_i));
endmodule

// File: rtl/tipc_acc.sv
module tipc_acc
  import tipc_pkg::*;
(
  input  logic              acc_en_i,
  input  logic              acc_we_i,
  input  logic [RING_W-1:0] acc_page_i,
  input  logic [RING_W-1:0] acc_ring_i,
  input  logic [OFF_W-1:0]  acc_off_i,
  output logic              rd_ok_o,
  output logic [NUM_RINGS-1:0] cppr_we_o,
  output logic [NUM_RINGS-1:0] ack_o
);
  logic grant;

  // lower page number = more privilege = more rings visible
  assign grant   = acc_en_i && (int'(acc_ring_i) + int'(acc_page_i) <= NUM_RINGS-1);
  assign rd_ok_o = grant && !acc_we_i;

  for (genvar r = 0; r < NUM_RINGS; r++) begin : g_sel
    logic hit;
    assign hit          = grant && acc_ring_i == RING_W'(r);
    assign cppr_we_o[r] = hit && acc_we_i && acc_off_i == OFF_CPPR;
    assign ack_o[r]     = hit && !acc_we_i && acc_off_i == OFF_ACK;
  end

  a_r8_ack_onehot: assert final ($onehot0(ack_o | cppr_we_o));
endmodule

// File: rtl/tipc_top.sv
module tipc_top
  import tipc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pres_en_i,
  input  logic [RING_W-1:0] pres_ring_i,
  input  logic [DATA_W-1:0] pres_prio_i,
  input  logic              acc_en_i,
  input  logic              acc_we_i,
  input  logic [RING_W-1:0] acc_page_i,
  input  logic [RING_W-1:0] acc_ring_i,
  input  logic [OFF_W-1:0]  acc_off_i,
  input  logic [DATA_W-1:0] acc_wdata_i,
  output logic [DATA_W-1:0] acc_rdata_o,
  output logic              hv_irq_o,
  output logic              os_irq_o
);
  logic                 rd_ok;
  logic [NUM_RINGS-1:0] cppr_we, ack, irq;
  logic [NUM_PRIO-1:0]  ipb  [NUM_RINGS];
  logic [DATA_W-1:0]    cppr [NUM_RINGS];
  logic [DATA_W-1:0]    pipr [NUM_RINGS];

  tipc_acc u_acc (
    .acc_en_i   (acc_en_i),
    .acc_we_i   (acc_we_i),
    .acc_page_i (acc_page_i),
    .acc_ring_i (acc_ring_i),
    .acc_off_i  (acc_off_i),
    .rd_ok_o    (rd_ok),
    .cppr_we_o  (cppr_we),
    .ack_o      (ack)
  );

  for (genvar r = 0; r < NUM_RINGS; r++) begin : g_ring
    tipc_ring u_ring (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .pres_en_i    (pres_en_i && pres_ring_i == RING_W'(r)),
      .pres_prio_i  (pres_prio_i),
      .cppr_we_i    (cppr_we[r]),
      .cppr_wdata_i (acc_wdata_i),
      .ack_i        (ack[r]),
      .ipb_o        (ipb[r]),
      .cppr_o       (cppr[r]),
      .pipr_o       (pipr[r]),
      .irq_o        (irq[r])
    );
  end

  always_comb begin
    acc_rdata_o = '0;
    if (rd_ok) begin
      unique case (acc_off_i)
        OFF_IPB:           acc_rdata_o = DATA_W'(ipb[acc_ring_i]);
        OFF_CPPR:          acc_rdata_o = cppr[acc_ring_i];
        OFF_PIPR, OFF_ACK: acc_rdata_o = pipr[acc_ring_i];
        default:           acc_rdata_o = '0;
      endcase
    end
  end

  assign os_irq_o = irq[1];
  assign hv_irq_o = irq[2] | irq[3];

  a_r8_denied_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_en_i && !acc_we_i && (int'(acc_ring_i) + int'(acc_page_i) > NUM_RINGS-1)
      |-> acc_rdata_o == '0);

  a_r8_denied_no_cppr_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_en_i && (int'(acc_ring_i) + int'(acc_page_i) > NUM_RINGS-1) && acc_ring_i == 2'd1
      |=> $stable(cppr[1]));

  a_r9_bad_offset_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_en_i && !acc_we_i && acc_off_i > 4'd3 |-> acc_rdata_o == '0);

  a_r1_reset_quiet: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> !hv_irq_o && !os_irq_o);
endmodule

// File: tb/tipc_top_tb.sv
module tipc_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] K_PR = 2'd0, K_WR = 2'd1, K_RD = 2'd2, K_IQ = 2'd3;

  typedef struct packed {
    logic [1:0] kind;
    logic [1:0] page;
    logic [1:0] ring;
    logic [3:0] off;
    logic [7:0] data;
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 44;
  localparam vec_t VEC [NV] = '{
    '{K_RD,2'd0,2'd1,4'd2,8'h00,8'hFF,4'd4},  // R4 empty -> FF
    '{K_RD,2'd0,2'd1,4'd1,8'h00,8'h00,4'd1},  // R1 cppr reset
    '{K_PR,2'd0,2'd1,4'd0,8'h05,8'h00,4'd3},
    '{K_RD,2'd0,2'd1,4'd0,8'h00,8'h04,4'd3},  // R3 bit 2
    '{K_RD,2'd0,2'd1,4'd2,8'h00,8'h05,4'd4},
    '{K_IQ,2'd0,2'd0,4'd0,8'h00,8'h00,4'd5},  // R5 5 !< 0
    '{K_WR,2'd2,2'd1,4'd1,8'hFF,8'h00,4'd6},
    '{K_IQ,2'd0,2'd0,4'd0,8'h00,8'h01,4'd6},  // R6 os up
    '{K_PR,2'd0,2'd1,4'd0,8'h02,8'h00,4'd3},
    '{K_RD,2'd3,2'd1,4'd2,8'h00,8'h00,4'd8},  // R8 user page denied
    '{K_RD,2'd2,2'd1,4'd2,8'h00,8'h02,4'd4},  // R4 two bits set
    '{K_PR,2'd0,2'd1,4'd0,8'h09,8'h00,4'd2},
    '{K_RD,2'd0,2'd1,4'd0,8'h00,8'h24,4'd2},  // R2 unchanged
    '{K_RD,2'd2,2'd1,4'd3,8'h00,8'h02,4'd7},  // R7 ack
    '{K_RD,2'd0,2'd1,4'd1,8'h00,8'h02,4'd7},
    '{K_RD,2'd0,2'd1,4'd0,8'h00,8'h04,4'd7},
    '{K_RD,2'd3,2'd1,4'd3,8'h00,8'h00,4'd8},  // R8 denied ack
    '{K_RD,2'd0,2'd1,4'd2,8'h00,8'h05,4'd8},  // R8 buffer untouched
    '{K_IQ,2'd0,2'd0,4'd0,8'h00,8'h00,4'd5},
    '{K_WR,2'd0,2'd1,4'd1,8'h06,8'h00,4'd6},
    '{K_IQ,2'd0,2'd0,4'd0,8'h00,8'h01,4'd6},
    '{K_WR,2'd2,2'd3,4'd1,8'hFF,8'h00,4'd8},
    '{K_RD,2'd0,2'd3,4'd1,8'h00,8'h00,4'd8},  // R8 denied write
    '{K_PR,2'd0,2'd3,4'd0,8'h00,8'h00,4'd3},
    '{K_IQ,2'd0,2'd0,4'd0,8'h00,8'h01,4'd5},
    '{K_WR,2'd0,2'd3,4'd1,8'h01,8'h00,4'd6},
    '{K_IQ,2'd0,2'd0,4'd0,8'h00,8'h03,4'd5},  // R5 hv from ring 3
    '{K_PR,2'd0,2'd2,4'd0,8'h07,8'h00,4'd3},
    '{K_WR,2'd1,2'd2,4'd1,8'hFF,8'h00,4'd6},
    '{K_RD,2'd1,2'd2,4'd2,8'h00,8'h07,4'd4},
    '{K_RD,2'd1,2'd3,4'd2,8'h00,8'h00,4'd8},
    '{K_RD,2'd0,2'd3,4'd3,8'h00,8'h00,4'd7},
    '{K_IQ,2'd0,2'd0,4'd0,8'h00,8'h03,4'd5},  // R5 hv from ring 2
    '{K_RD,2'd1,2'd2,4'd3,8'h00,8'h07,4'd7},
    '{K_IQ,2'd0,2'd0,4'd0,8'h00,8'h01,4'd7},
    '{K_RD,2'd0,2'd0,4'd3,8'h00,8'hFF,4'd7},  // R7 empty ack
    '{K_RD,2'd3,2'd0,4'd1,8'h00,8'hFF,4'd8},  // R8 user sees ring 0
    '{K_RD,2'd0,2'd1,4'd3,8'h00,8'h05,4'd7},
    '{K_IQ,2'd0,2'd0,4'd0,8'h00,8'h00,4'd7},
    '{K_WR,2'd0,2'd1,4'd0,8'hFF,8'h00,4'd9},
    '{K_RD,2'd0,2'd1,4'd0,8'h00,8'h00,4'd9},  // R9 buffer not writable
    '{K_RD,2'd0,2'd1,4'd7,8'h00,8'h00,4'd9},  // R9 unused offset
    '{K_PR,2'd0,2'd0,4'd0,8'h01,8'h00,4'd5},
    '{K_IQ,2'd0,2'd0,4'd0,8'h00,8'h00,4'd5}   // R5 ring 0 silent
  };

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       pres_en = 1'b0, acc_en = 1'b0, acc_we = 1'b0;
  logic [1:0] pres_ring = '0, acc_page = '0, acc_ring = '0;
  logic [7:0] pres_prio = '0, acc_wdata = '0;
  logic [3:0] acc_off = '0;
  logic [7:0] rdata;
  logic       hv_irq, os_irq;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tipc_top u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .pres_en_i(pres_en), .pres_ring_i(pres_ring), .pres_prio_i(pres_prio),
    .acc_en_i(acc_en), .acc_we_i(acc_we), .acc_page_i(acc_page),
    .acc_ring_i(acc_ring), .acc_off_i(acc_off), .acc_wdata_i(acc_wdata),
    .acc_rdata_o(rdata), .hv_irq_o(hv_irq), .os_irq_o(os_irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    pres_en = 1'b0; acc_en = 1'b0; acc_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] pg, input logic [1:0] rg, input logic [3:0] off,
                    input logic [7:0] exp, input string req);
    @(negedge clk);
    idle();
    acc_en = 1'b1; acc_page = pg; acc_ring = rg; acc_off = off;
    #1 check(req, rdata, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 3);
    // R1 reset state
    check("R1", {6'd0, hv_irq, os_irq}, 8'h00);
    @(negedge clk) rst_n = 1'b1;
    #1 check("R1", {6'd0, hv_irq, os_irq}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      idle();
      case (VEC[i].kind)
        K_PR: begin pres_en = 1'b1; pres_ring = VEC[i].ring; pres_prio = VEC[i].data; end
        K_WR: begin acc_en = 1'b1; acc_we = 1'b1; acc_page = VEC[i].page;
                    acc_ring = VEC[i].ring; acc_off = VEC[i].off; acc_wdata = VEC[i].data; end
        K_RD: begin acc_en = 1'b1; acc_page = VEC[i].page;
                    acc_ring = VEC[i].ring; acc_off = VEC[i].off; end
        default: ;
      endcase
      #1;
      if (VEC[i].kind == K_RD)
        check($sformatf("R%0d vec%0d", VEC[i].req, i), rdata, VEC[i].exp);
      else if (VEC[i].kind == K_IQ)
        check($sformatf("R%0d vec%0d", VEC[i].req, i), {6'd0, hv_irq, os_irq}, VEC[i].exp);
    end

    // R3 R4 ring 0: all bits set, top wins
    @(negedge clk) idle();
    for (int p = 7; p >= 0; p--) begin
      @(negedge clk); idle();
      pres_en = 1'b1; pres_ring = 2'd0; pres_prio = 8'(p);
    end
    rd(2'd3, 2'd0, 4'd0, 8'hFF, "R3");
    rd(2'd3, 2'd0, 4'd2, 8'h00, "R4");

    // R1 mid-run reset
    @(negedge clk); idle(); rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    #1 check("R1", {6'd0, hv_irq, os_irq}, 8'h00);
    rd(2'd0, 2'd1, 4'd2, 8'hFF, "R1");
    rd(2'd0, 2'd3, 4'd1, 8'h00, "R1");
    rd(2'd0, 2'd0, 4'd0, 8'h00, "R1");
    @(negedge clk) idle();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule